// File: doc/BRIEF.md
# TRNG Test and Configuration Register Bank

This block holds the limit and timing settings that govern a true random number generator's entropy sampling and self-checks, behind a 32-bit word-addressed register port. One control bit chooses between program mode, where software may change limits, and run mode, where the limits are frozen and the generator samples. Three addresses hold two meanings. In program mode they show a stored limit. In run mode they show a live statistic taken from the test engines.

The stored entropy delay and the frequency limits drive output pins straight to the sampling logic. While running, every valid frequency count is checked against the stored window. A count outside the window latches a fault flag. The flag stays set until software returns the bank to program mode. Software normally sets the delay to 800 clocks per sample and the window to 400..6400, then clears the mode bit.

Top module: `trng_cfg_bank`

## Requirements
- R1: After reset the bank is in program mode (control word 0 reads 0x0001_0000), the seed word (word 4) reads 0x00C8_0000 (entropy delay 200 in bits 31:16), and every other limit and the fault flag are zero.
- R2: Bit 16 of word 0 is the mode bit (1 = program, 0 = run). A write to word 0 always updates it, in either mode. All other bits of word 0 read as zero.
- R3: Words 2 (poker range), 3 (poker max), 5 (sparse-bit limit), 6 (frequency min), 7 (frequency max) and bits 31:16 of word 4 take writes only while the mode bit is 1. In run mode such writes leave the stored value unchanged.
- R4: Bits 15:0 of word 4 take a write in either mode and read back as written.
- R5: In run mode, reads of word 3, word 5 and word 7 return the live inputs poker_sq_in, total_samples_in and freq_count_in. In program mode the same reads return the stored limits.
- R6: Words 8 to 63 read as zero, and writes to them change nothing.
- R7: In run mode, a freq_count_vld pulse with a count below the minimum or above the maximum sets the fault flag. The flag appears on freq_fault and in bit 0 of word 1 from the next cycle. It stays set through later in-range counts, and writes to word 1 do not clear it.
- R8: The fault flag clears once the mode bit is 1. Counts equal to the minimum or the maximum are in range. No count raises the flag in program mode.
- R9: entropy_delay, freq_min and freq_max always show the stored values of word 4 bits 31:16, word 6 and word 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| reg_addr | input | 6 | Word index within the 0x100-byte bank |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| poker_sq_in | input | 32 | Live poker square result |
| total_samples_in | input | 32 | Live total sample count |
| freq_count_in | input | 32 | Live frequency count |
| freq_count_vld | input | 1 | freq_count_in holds a fresh count this cycle |
| prog_mode | output | 1 | Mode bit (1 = program) |
| entropy_delay | output | 16 | Configured clocks per sample |
| freq_min | output | 32 | Configured minimum frequency count |
| freq_max | output | 32 | Configured maximum frequency count |
| freq_fault | output | 1 | Sticky frequency-count fault |

## Verification
The bench checks that the shared addresses switch meaning when the mode bit changes. A design that decoded on the wrong mode would return a stale limit in place of the live statistic. It writes the seed word in run mode, where a design that guarded the whole word, or none of it, would fail the split read-back. It drives counts exactly at the window edges and one step outside them, which catches an off-by-one comparison. It also checks that the fault stays set through in-range counts and through a write to the misc word, and that only program mode clears it.

// File: rtl/trng_cfg_pkg.sv
package trng_cfg_pkg;
  localparam int DW        = 32;
  localparam int AW        = 6;
  localparam int MODE_BIT  = 16;
  localparam int DLY_LSB   = 16;
  localparam int DLY_W     = DW - DLY_LSB;
  localparam int DLY_RST   = 200;
  localparam int NUM_DEF   = 8;

  localparam logic [AW-1:0] W_CTL   = AW'(0);
  localparam logic [AW-1:0] W_MISC  = AW'(1);
  localparam logic [AW-1:0] W_PKRNG = AW'(2);
  localparam logic [AW-1:0] W_PKMAX = AW'(3);
  localparam logic [AW-1:0] W_SEED  = AW'(4);
  localparam logic [AW-1:0] W_SBLIM = AW'(5);
  localparam logic [AW-1:0] W_FMIN  = AW'(6);
  localparam logic [AW-1:0] W_FMAX  = AW'(7);

  typedef struct packed {
    logic [DW-1:0] pk_rng;
    logic [DW-1:0] pk_max;
    logic [DW-1:0] seed;
    logic [DW-1:0] sb_lim;
    logic [DW-1:0] f_min;
    logic [DW-1:0] f_max;
  } lim_t;
endpackage

// File: rtl/trng_cfg_regs.sv
module trng_cfg_regs
  import trng_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          prog_q,
  output lim_t          lim_q
);
  logic lim_we;
  assign lim_we = wr_en && prog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      lim_q  <= '0;
      lim_q.seed[DW-1:DLY_LSB] <= DLY_W'(DLY_RST);
    end else begin
      if (wr_en && wr_addr == W_CTL) prog_q <= wr_data[MODE_BIT];
      if (wr_en && wr_addr == W_SEED) begin
        lim_q.seed[DLY_LSB-1:0] <= wr_data[DLY_LSB-1:0];
        if (prog_q) lim_q.seed[DW-1:DLY_LSB] <= wr_data[DW-1:DLY_LSB];
      end
      if (lim_we) begin
        case (wr_addr)
          W_PKRNG: lim_q.pk_rng <= wr_data;
          W_PKMAX: lim_q.pk_max <= wr_data;
          W_SBLIM: lim_q.sb_lim <= wr_data;
          W_FMIN:  lim_q.f_min  <= wr_data;
          W_FMAX:  lim_q.f_max  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R3: limits frozen while running
  p_lim_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_q |=> $stable(lim_q.f_min) && $stable(lim_q.f_max) &&
                $stable(lim_q.pk_max) && $stable(lim_q.seed[DW-1:DLY_LSB]));

  // R2: mode bit write always accepted
  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == W_CTL) |=> prog_q == $past(wr_data[MODE_BIT]));
endmodule

// File: rtl/trng_freq_mon.sv
module trng_freq_mon
  import trng_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          cnt_vld,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          fault_q
);
  logic out_of_win;
  assign out_of_win = (cnt < lo) || (cnt > hi);

  always_ff @(posedge clk) begin
    if (!rst_n)                          fault_q <= 1'b0;
    else if (prog)                       fault_q <= 1'b0;
    else if (cnt_vld && out_of_win)      fault_q <= 1'b1;
  end

  p_fault_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog && cnt_vld && out_of_win) |=> fault_q);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !prog) |=> fault_q);

  p_fault_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> !fault_q);
endmodule

// File: rtl/trng_cfg_rdmux.sv
module trng_cfg_rdmux
  import trng_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          prog,
  input  logic          fault,
  input  lim_t          lim,
  input  logic [DW-1:0] pk_sq,
  input  logic [DW-1:0] tot_smp,
  input  logic [DW-1:0] f_cnt,
  output logic [DW-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    case (addr)
      W_CTL:   rd_data[MODE_BIT] = prog;
      W_MISC:  rd_data[0] = fault;
      W_PKRNG: rd_data = lim.pk_rng;
      W_PKMAX: rd_data = prog ? lim.pk_max : pk_sq;
      W_SEED:  rd_data = lim.seed;
      W_SBLIM: rd_data = prog ? lim.sb_lim : tot_smp;
      W_FMIN:  rd_data = lim.f_min;
      W_FMAX:  rd_data = prog ? lim.f_max : f_cnt;
      default: rd_data = '0;
    endcase
  end

  // R6: reserved space reads zero
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= AW'(NUM_DEF)) |-> rd_data == '0);
endmodule

// File: rtl/trng_cfg_bank.sv
module trng_cfg_bank
  import trng_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wr_data,
  output logic [31:0]   reg_rd_data,
  input  logic [31:0]   poker_sq_in,
  input  logic [31:0]   total_samples_in,
  input  logic [31:0]   freq_count_in,
  input  logic          freq_count_vld,
  output logic          prog_mode,
  output logic [15:0]   entropy_delay,
  output logic [31:0]   freq_min,
  output logic [31:0]   freq_max,
  output logic          freq_fault
);
  logic prog_q;
  logic fault_q;
  lim_t lim_q;

  trng_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wr_data), .prog_q(prog_q), .lim_q(lim_q)
  );

  trng_freq_mon u_mon (
    .clk(clk), .rst_n(rst_n), .prog(prog_q), .cnt_vld(freq_count_vld),
    .cnt(freq_count_in), .lo(lim_q.f_min), .hi(lim_q.f_max), .fault_q(fault_q)
  );

  trng_cfg_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .prog(prog_q), .fault(fault_q),
    .lim(lim_q), .pk_sq(poker_sq_in), .tot_smp(total_samples_in),
    .f_cnt(freq_count_in), .rd_data(reg_rd_data)
  );

  assign prog_mode     = prog_q;
  assign entropy_delay = lim_q.seed[DW-1:DLY_LSB];
  assign freq_min      = lim_q.f_min;
  assign freq_max      = lim_q.f_max;
  assign freq_fault    = fault_q;
endmodule

// File: tb/tb_trng_cfg_bank.sv
module tb_trng_cfg_bank;
  logic clk = 0;
  logic rst_n = 0;
  logic we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [31:0] pk_sq = 32'hABCD_0001, tot = 32'h0000_5A5A, fcnt = 32'd1000;
  logic fvld = 0;
  logic prog, fault;
  logic [15:0] dly;
  logic [31:0] fmin, fmax;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  trng_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(we), .reg_addr(addr),
    .reg_wr_data(wdata), .reg_rd_data(rdata), .poker_sq_in(pk_sq),
    .total_samples_in(tot), .freq_count_in(fcnt), .freq_count_vld(fvld),
    .prog_mode(prog), .entropy_delay(dly), .freq_min(fmin), .freq_max(fmax),
    .freq_fault(fault)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  waddr;
    logic [31:0] wd;
    logic [5:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd6, 32'd400,        6'd6,  32'd400,        8'd3}, // R3 min in prog
    '{1'b1, 6'd7, 32'd6400,       6'd7,  32'd6400,       8'd3}, // R3 max in prog
    '{1'b1, 6'd4, 32'h0320_1234,  6'd4,  32'h0320_1234,  8'd4}, // R4 seed
    '{1'b1, 6'd3, 32'h55,         6'd3,  32'h55,         8'd5}, // R5 prog view
    '{1'b1, 6'd5, 32'h77,         6'd5,  32'h77,         8'd5}, // R5 prog view
    '{1'b1, 6'd2, 32'h99,         6'd2,  32'h99,         8'd3}, // R3 poker range
    '{1'b1, 6'd0, 32'hFFFE_FFFF,  6'd0,  32'h0,          8'd2}, // R2 enter run
    '{1'b0, 6'd0, 32'h0,          6'd3,  32'hABCD_0001,  8'd5}, // R5 live poker
    '{1'b0, 6'd0, 32'h0,          6'd5,  32'h0000_5A5A,  8'd5}, // R5 live samples
    '{1'b1, 6'd6, 32'd5,          6'd6,  32'd400,        8'd3}, // R3 blocked
    '{1'b1, 6'd4, 32'hFFFF_BEEF,  6'd4,  32'h0320_BEEF,  8'd4}, // R4 split
    '{1'b1, 6'd7, 32'd1,          6'd7,  32'd1000,       8'd5}, // R5 live count
    '{1'b1, 6'd40, 32'hDEAD_BEEF, 6'd40, 32'h0,          8'd6}, // R6 reserved
    '{1'b1, 6'd0, 32'h0001_0000,  6'd7,  32'd6400,       8'd2}  // R2 back to prog
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic cnt_pulse(input logic [31:0] c);
    @(negedge clk); fcnt = c; fvld = 1;
    @(negedge clk); fvld = 0; #1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'd0, v); chk(v, 32'h0001_0000, "R1 ctrl");
    rd(6'd4, v); chk(v, 32'h00C8_0000, "R1 seed");
    rd(6'd7, v); chk(v, 32'h0, "R1 fmax");
    rd(6'd1, v); chk(v, 32'h0, "R1 misc");
    chk({16'h0, dly}, 32'd200, "R1 delay pin");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].waddr, VECS[i].wd);
      rd(VECS[i].raddr, v);
      chk(v, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R9 outputs
    chk({16'h0, dly}, 32'd800, "R9 entropy_delay");
    chk(fmin, 32'd400, "R9 freq_min");
    chk(fmax, 32'd6400, "R9 freq_max");

    // R8 no fault in program mode
    cnt_pulse(32'd10);
    chk({31'b0, fault}, 32'd0, "R8 prog no fault");

    wr(6'd0, 32'h0);
    cnt_pulse(32'd400);  chk({31'b0, fault}, 32'd0, "R8 at min");
    cnt_pulse(32'd6400); chk({31'b0, fault}, 32'd0, "R8 at max");
    cnt_pulse(32'd399);  chk({31'b0, fault}, 32'd1, "R7 below min");
    cnt_pulse(32'd1000); chk({31'b0, fault}, 32'd1, "R7 sticky");
    wr(6'd1, 32'h0);
    rd(6'd1, v); chk(v, 32'h1, "R7 misc write ignored");
    wr(6'd0, 32'h0001_0000);
    rd(6'd1, v); chk(v, 32'h0, "R8 cleared by prog");
    wr(6'd0, 32'h0);
    cnt_pulse(32'd6401); chk({31'b0, fault}, 32'd1, "R7 above max");
    rd(6'd40, v); chk(v, 32'h0, "R6 reserved still zero");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule